// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every clock cycle, which of several hardware thread contexts supplies the program counter for instruction fetch. Each context owns a PC register inside the block. The PC of the chosen thread is presented at the output and advances by one fetch step whenever a fetch is actually issued. PCs of threads that are not fetched keep their value.

Two scheduling disciplines are available through a mode input. In interleaved mode the chosen thread can change every cycle. The selector rotates round-robin over the threads that can run and skips any that are not ready. A 2-bit weight per thread stretches that thread's turn. In switch-on-stall mode the selector stays on one thread and issues from it every cycle it is ready. It moves to another thread only when the current thread reports a long-latency stall, such as a miss in the second cache level. On that switch it requests a pipeline flush and holds fetch off for a programmable refill window.

A thread named by a long-stall event is marked as blocked and is not picked in either mode. The mark clears when the thread's ready flag has been seen low and then high again, which is how the miss handler signals that the data has returned.

Top module: `mt_fetch_sel`

## Requirements
- R1: While reset is held, `fetch_valid` and `flush_req` are low. After reset, thread t's PC starts at `PC_BASE + t*PC_STRIDE` (defaults 0 and 0x1000), and selection starts at thread 0.
- R2: In interleaved mode (`mode_coarse`=0), with all weights 0 and all threads ready, fetch goes to threads 0,1,2,3,0,… on consecutive cycles.
- R3: A thread whose `thr_ready` bit is low is never fetched. In interleaved mode the rotation skips it and goes to the next ready thread in increasing index order, wrapping around.
- R4: In interleaved mode, a thread of weight w (bits `2t+1:2t` of `thr_weight`) that stays ready receives w+1 consecutive fetch slots per turn before the rotation moves on.
- R5: When no thread can be fetched, `fetch_valid` is low in that cycle and the rotation pointer does not move. Once threads become ready again, the next pick is the same one that would have followed without the idle cycles.
- R6: `fetch_pc` equals the PC of the thread on `sel_tid`. On each cycle with `fetch_valid` high, that thread's PC grows by `PC_STEP` (default 4). All other PCs are unchanged.
- R7: In switch-on-stall mode the selector keeps issuing from the current thread. If that thread's ready bit drops, fetch pauses (`fetch_valid` low) with no switch, and it resumes on the same thread.
- R8: In switch-on-stall mode, a long-stall event naming the current thread raises `flush_req` and holds `fetch_valid` low in that cycle. Fetch then stays low for `REFILL_CYCLES` further cycles (default 4). After that, the next eligible thread in rotation order, excluding the stalled one, is fetched.
- R9: A long-stall event for a thread other than the current one raises no flush and causes no switch. It only blocks that thread from selection in both modes, from the next cycle until its ready bit has gone low and then high again.
- R10: A change of `mode_coarse` takes effect one cycle later. In the cycle of the change the previous mode's rule still picks the thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_coarse | input | 1 | 0 = interleave every cycle, 1 = switch only on long stall |
| thr_ready | input | NTHREADS | Per-thread ready flag, bit t for thread t |
| lstall_evt | input | 1 | Long-latency stall event pulse |
| lstall_tid | input | TID_W | Thread that suffered the long stall |
| thr_weight | input | NTHREADS*2 | Per-thread 2-bit priority weight |
| sel_tid | output | TID_W | Selected thread |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_pc | output | PC_W | Program counter of the selected thread |
| flush_req | output | 1 | Pipeline drain request on a thread switch |

## Verification
The hardest situation to reach from the ports is the combination of blocked marks and the rotation wrapping back onto the current thread. It needs every other thread blocked by earlier long-stall events, while their ready flags stay high. The stimulus gets there by issuing two switch-on-stall switches and one off-thread event while in switch-on-stall mode. It then returns to interleaved mode, where the only unblocked thread must keep winning. Finally it lowers and raises one blocked thread's ready bit and checks that this thread rejoins the rotation exactly one cycle after the rise.

// File: rtl/mt_sel_pkg.sv
// Package: shared types for the fetch thread selector.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package mt_sel_pkg;

    typedef enum logic {
        PH_RUN    = 1'b0,
        PH_REFILL = 1'b1
    } phase_e;

    typedef enum logic {
        SCHED_FINE   = 1'b0,
        SCHED_COARSE = 1'b1
    } sched_e;

endpackage

// File: rtl/mt_rot_find.sv
// Rotating finder: returns the first eligible thread after 'base' in
// increasing index order, wrapping. If none is found and INCL_SELF is set,
// 'base' itself is returned when eligible. Purely combinational.
// Assumes N >= 2.
module mt_rot_find #(
    parameter int N         = 4,
    parameter int TW        = 2,
    parameter bit INCL_SELF = 1'b1
) (
    input  logic [N-1:0]  elig,
    input  logic [TW-1:0] base,
    output logic          found,
    output logic [TW-1:0] idx
);

    // scan offsets from far to near so that the nearest eligible wins
    always_comb begin
        found = 1'b0;
        idx   = base;
        for (int k = N - 1; k >= 1; k--) begin
            int c;
            c = (int'(base) + k) % N;
            if (elig[c]) begin
                found = 1'b1;
                idx   = TW'(c);
            end
        end
        if (INCL_SELF && !found && elig[base]) begin
            found = 1'b1;
        end
    end

endmodule

// File: rtl/mt_stall_marks.sv
// Blocked-thread marks: a long-stall event sets the named thread's mark.
// The mark clears on a low-to-high transition of that thread's ready flag.
// A set in the same cycle as a clear wins.
module mt_stall_marks #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ready,
    input  logic          evt,
    input  logic [TW-1:0] evt_tid,
    output logic [N-1:0]  marks
);

    logic [N-1:0] ready_q;

    // remember last cycle's ready flags for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= ready;
    end

    for (genvar t = 0; t < N; t++) begin : g_mark
        // per-thread sticky mark with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)                             marks[t] <= 1'b0;
            else if (evt && (evt_tid == TW'(t)))    marks[t] <= 1'b1;
            else if (ready[t] && !ready_q[t])       marks[t] <= 1'b0;
        end
    end

    // R9: an event marks its thread on the next cycle
    p_mark_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt)) |-> marks[$past(evt_tid)]);

endmodule

// File: rtl/mt_pc_bank.sv
// Per-thread program counters. The addressed thread's PC advances by STEP
// when 'adv' is high. The read port is combinational.
// Assumes adv_tid and rd_tid are below N.
module mt_pc_bank #(
    parameter int          N      = 4,
    parameter int          TW     = 2,
    parameter int          PW     = 32,
    parameter logic [31:0] BASE   = 32'h0,
    parameter logic [31:0] STRIDE = 32'h1000,
    parameter logic [31:0] STEP   = 32'd4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [TW-1:0] adv_tid,
    input  logic [TW-1:0] rd_tid,
    output logic [PW-1:0] rd_pc
);

    logic [PW-1:0] pc [N];

    for (genvar t = 0; t < N; t++) begin : g_pc
        // thread t PC: reset to its own start address, step on its fetch
        always_ff @(posedge clk) begin
            if (!rst_n)                          pc[t] <= PW'(BASE + STRIDE * t);
            else if (adv && adv_tid == TW'(t))   pc[t] <= pc[t] + PW'(STEP);
        end

        // R6: a thread that was not fetched keeps its PC
        p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !($past(adv) && $past(adv_tid) == TW'(t)))
            |-> pc[t] == $past(pc[t]));
    end

    assign rd_pc = pc[rd_tid];

endmodule

// File: rtl/mt_fetch_sel.sv
// Fetch thread selector (top). It picks a thread per cycle in either
// interleaved mode (weighted round-robin that skips unready or blocked
// threads) or switch-on-stall mode (stay on one thread, flush and refill
// on its long stall). Outputs are combinational from state and inputs.
// Assumes REFILL_CYCLES >= 1 and NTHREADS >= 2.
module mt_fetch_sel
    import mt_sel_pkg::*;
#(
    parameter int          NTHREADS      = 4,
    parameter int          WW            = 2,
    parameter int          PC_W          = 32,
    parameter int          REFILL_CYCLES = 4,
    parameter logic [31:0] PC_BASE       = 32'h0,
    parameter logic [31:0] PC_STRIDE     = 32'h1000,
    parameter logic [31:0] PC_STEP       = 32'd4,
    localparam int         TID_W         = $clog2(NTHREADS),
    localparam int         CW            = WW + 1,
    localparam int         RCW           = $clog2(REFILL_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_coarse,
    input  logic [NTHREADS-1:0]    thr_ready,
    input  logic                   lstall_evt,
    input  logic [TID_W-1:0]       lstall_tid,
    input  logic [NTHREADS*WW-1:0] thr_weight,
    output logic [TID_W-1:0]       sel_tid,
    output logic                   fetch_valid,
    output logic [PC_W-1:0]        fetch_pc,
    output logic                   flush_req
);

    sched_e           mode_q;
    phase_e           phase;
    logic [TID_W-1:0] cur;
    logic [CW-1:0]    cnt;
    logic [RCW-1:0]   rcnt;

    logic [NTHREADS-1:0] marks;
    logic [NTHREADS-1:0] elig;
    logic [WW-1:0]       w_cur;
    logic                keep_turn;
    logic                f_found, s_found;
    logic [TID_W-1:0]    f_idx, s_idx;
    logic                switch_now;

    mt_stall_marks #(.N(NTHREADS), .TW(TID_W)) u_marks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (thr_ready),
        .evt     (lstall_evt),
        .evt_tid (lstall_tid),
        .marks   (marks)
    );

    assign elig  = thr_ready & ~marks;
    assign w_cur = thr_weight[cur*WW +: WW];

    // rotation candidate for interleaved mode (may wrap onto cur)
    mt_rot_find #(.N(NTHREADS), .TW(TID_W), .INCL_SELF(1'b1)) u_find_fine (
        .elig  (elig),
        .base  (cur),
        .found (f_found),
        .idx   (f_idx)
    );

    // switch target for switch-on-stall mode (never cur)
    mt_rot_find #(.N(NTHREADS), .TW(TID_W), .INCL_SELF(1'b0)) u_find_switch (
        .elig  (elig),
        .base  (cur),
        .found (s_found),
        .idx   (s_idx)
    );

    // selection and output decode for the current cycle
    always_comb begin
        keep_turn  = elig[cur] && (cnt <= CW'(w_cur));
        switch_now = rst_n && (phase == PH_RUN) && (mode_q == SCHED_COARSE)
                     && lstall_evt && (lstall_tid == cur);
        sel_tid    = cur;
        fetch_valid = 1'b0;
        if (rst_n && phase == PH_RUN) begin
            if (mode_q == SCHED_FINE) begin
                fetch_valid = keep_turn || f_found;
                if (!keep_turn && f_found) sel_tid = f_idx;
            end else begin
                fetch_valid = elig[cur] && !switch_now;
            end
        end
        flush_req = switch_now;
    end

    // scheduling state: mode register, turn pointer, slot count, refill timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SCHED_FINE;
            phase  <= PH_RUN;
            cur    <= '0;
            cnt    <= '0;
            rcnt   <= '0;
        end else begin
            mode_q <= mode_coarse ? SCHED_COARSE : SCHED_FINE;
            if (phase == PH_REFILL) begin
                if (rcnt == RCW'(1)) phase <= PH_RUN;
                rcnt <= rcnt - RCW'(1);
            end else if (mode_q == SCHED_COARSE) begin
                cnt <= '0;
                if (switch_now) begin
                    cur   <= s_found ? s_idx : cur;
                    phase <= PH_REFILL;
                    rcnt  <= RCW'(REFILL_CYCLES);
                end
            end else if (fetch_valid) begin
                if (keep_turn) begin
                    cnt <= cnt + CW'(1);
                end else begin
                    cur <= f_idx;
                    cnt <= CW'(1);
                end
            end
        end
    end

    mt_pc_bank #(
        .N(NTHREADS), .TW(TID_W), .PW(PC_W),
        .BASE(PC_BASE), .STRIDE(PC_STRIDE), .STEP(PC_STEP)
    ) u_pcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (fetch_valid),
        .adv_tid (sel_tid),
        .rd_tid  (sel_tid),
        .rd_pc   (fetch_pc)
    );

    // R1: nothing is fetched or flushed while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!fetch_valid && !flush_req));

    // R3: a fetched thread is always ready
    p_ready_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> thr_ready[sel_tid]);

    // R5: no ready thread means no fetch
    p_idle_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_ready == '0) |-> !fetch_valid);

    // R5: an idle interleaved cycle leaves the pointer in place
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SCHED_FINE && phase == PH_RUN && !fetch_valid) |=> $stable(cur));

    // R7: back-to-back switch-on-stall fetches stay on one thread
    p_coarse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == SCHED_COARSE && $past(mode_q) == SCHED_COARSE
         && $past(fetch_valid) && fetch_valid) |-> sel_tid == $past(sel_tid));

    // R8: the flush cycle and the cycle after it carry no fetch
    p_flush_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !fetch_valid ##1 !fetch_valid);

    // R9: a stall event naming another thread never flushes
    p_no_flush_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lstall_evt && lstall_tid != cur) |-> !flush_req);

endmodule

// File: tb/mt_fetch_sel_tb.sv
`timescale 1ns/1ps
module mt_fetch_sel_tb;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_coarse;
    logic [N-1:0]  thr_ready;
    logic          lstall_evt;
    logic [1:0]    lstall_tid;
    logic [2*N-1:0] thr_weight;
    logic [1:0]    sel_tid;
    logic          fetch_valid;
    logic [31:0]   fetch_pc;
    logic          flush_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mpc [N];

    always #2.5 clk = ~clk;

    mt_fetch_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_coarse (mode_coarse),
        .thr_ready   (thr_ready),
        .lstall_evt  (lstall_evt),
        .lstall_tid  (lstall_tid),
        .thr_weight  (thr_weight),
        .sel_tid     (sel_tid),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .flush_req   (flush_req)
    );

    typedef struct packed {
        logic       mode;
        logic [3:0] rdy;
        logic [7:0] w;
        logic       ls;
        logic [1:0] lt;
        logic       ev;
        logic [1:0] et;
        logic       ef;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        // R2 plain rotation
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd2},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd2},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd2},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd2},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd2},
        // R3 skip thread 1
        '{1'b0, 4'hD, 8'h00, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd3},
        '{1'b0, 4'hD, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd3},
        '{1'b0, 4'hD, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd3},
        // R5 nothing ready, pointer held
        '{1'b0, 4'h0, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd5},
        '{1'b0, 4'h0, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd5},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd5},
        // R4 thread 1 weight 2 -> three slots
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd4},
        '{1'b0, 4'hF, 8'h08, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd4},
        // R10 mode input changes, old rule still rotates
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd10},
        // R7 stay on thread 3, short stall pauses without switch
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd7},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd7},
        '{1'b1, 4'h7, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd7},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 4'd7},
        // R8 long stall on thread 3: flush, four idle, then thread 0
        '{1'b1, 4'hF, 8'h00, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd8},
        // R9 event on thread 2 while 0 runs: no flush
        '{1'b1, 4'hF, 8'h00, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, 4'd9},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 4'd9},
        // R8 long stall on thread 0: switch to thread 1
        '{1'b1, 4'hF, 8'h00, 1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'd8},
        '{1'b1, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd8},
        // R10 back to interleaved, coarse rule still holds this cycle
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd10},
        // R9 threads 0,2,3 blocked: only thread 1 wins
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd9},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd9},
        '{1'b0, 4'hB, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd9},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd9},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 4'd9},
        '{1'b0, 4'hF, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 4'd9}
    };

    task automatic model_reset();
        for (int t = 0; t < N; t++) mpc[t] = 32'h1000 * t;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // full output check against an expected fetch decision (R6 PC model)
    task automatic chk_out(input string req, input logic ev,
                           input logic [1:0] et, input logic ef);
        chk(req, "fetch_valid", 32'(fetch_valid), 32'(ev));
        chk(req, "flush_req", 32'(flush_req), 32'(ef));
        if (ev) begin
            chk(req, "sel_tid", 32'(sel_tid), 32'(et));
            chk({req, "/R6"}, "fetch_pc", fetch_pc, mpc[et]);
            mpc[et] = mpc[et] + 32'd4;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode_coarse = 1'b0; thr_ready = '0;
        lstall_evt = 1'b0; lstall_tid = '0; thr_weight = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: quiet during reset
        chk("R1", "fetch_valid in reset", 32'(fetch_valid), 32'd0);
        chk("R1", "flush_req in reset", 32'(flush_req), 32'd0);
        chk("R1", "sel_tid in reset", 32'(sel_tid), 32'd0);
        chk("R1", "thread0 start pc", fetch_pc, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst_n       = 1'b1;
            mode_coarse = VEC[i].mode;
            thr_ready   = VEC[i].rdy;
            thr_weight  = VEC[i].w;
            lstall_evt  = VEC[i].ls;
            lstall_tid  = VEC[i].lt;
            #1;
            chk_out($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ev, VEC[i].et, VEC[i].ef);
        end

        // R1: reset in mid-run restores start PCs; only thread 2 ready
        @(negedge clk);
        rst_n = 1'b0; lstall_evt = 1'b0; mode_coarse = 1'b0;
        thr_ready = 4'h4; thr_weight = '0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "fetch_valid held reset", 32'(fetch_valid), 32'd0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_out("R1", 1'b1, 2'd2, 1'b0);
        // R3: lone ready thread wraps onto itself
        @(negedge clk);
        #1;
        chk_out("R3", 1'b1, 2'd2, 1'b0);

        // R9: event on an unselected thread in interleaved mode, no flush
        @(negedge clk);
        thr_ready = 4'hF; lstall_evt = 1'b1; lstall_tid = 2'd3;
        #1;
        chk_out("R9", 1'b1, 2'd3, 1'b0);
        @(negedge clk);
        lstall_evt = 1'b0;
        #1;
        chk_out("R9", 1'b1, 2'd0, 1'b0);

        @(negedge clk);
        finish_run();
    end

endmodule